// File: doc/BRIEF.md
# Two-Bank Masked Interrupt Aggregator

This block gathers 64 level-sensitive interrupt sources, split into a high bank and a low bank of 32 lines each, into a single interrupt request for a processor. Each bank holds a status word that tracks its source lines, an enable word written by software, and a write-one-to-clear port that knocks status bits down for one cycle. The request output is raised whenever any bit is both pending and enabled in either bank.

Software reaches the block over a simple register bus with separate read and write strobes. The bus carries little-endian words, so every write word is byte-reversed before it is used as an enable value or a clear mask. Reads return the enabled pending bits of a bank, the enable words as stored, and a constant version word. A reset-to-zero, two-state machine holds the request: IRQ_QUIET moves to IRQ_RAISED when any enabled bit is pending, and IRQ_RAISED returns to IRQ_QUIET when none is. In both states the machine stays put when that condition does not change. The request output is high exactly in IRQ_RAISED.

Top module: `irq_merge_top`

## Requirements
- R1: `cpu_irq` is a registered output. After a clock edge it equals the OR, taken just before that edge, over both banks of (status AND enable), so it changes one clock after the status or enable change that causes it.
- R2: Each status bit follows its source line. A line that is high at a clock edge sets its bit, and a line that is low clears it, when no clear write to that bank falls on the same edge.
- R3: A write to offset 0x14 (high bank) or 0x24 (low bank) replaces that bank's enable word with the byte-reversed write data. A read of the same offset returns the stored enable word. Enable words change on no other event.
- R4: A write to offset 0x18 (high bank) or 0x28 (low bank) clears, on that edge, every status bit of the bank whose byte-reversed data bit is 1, and the other bits keep tracking their sources. A source still held high sets its bit again on the next edge.
- R5: A read of offset 0x10 (high bank) or 0x20 (low bank) returns that bank's status AND enable.
- R6: A read of offset 0x00 returns 0x02000000. A write to offset 0x00 changes nothing.
- R7: Byte reversal maps write-data bits [7:0] to [31:24], [15:8] to [23:16], [23:16] to [15:8] and [31:24] to [7:0].
- R8: Reads of offsets 0x1C, 0x2C, 0x18, 0x28 and any unmapped offset return zero. Writes to 0x1C, 0x2C, the status offsets and any unmapped offset change nothing. `bus_rdata` is zero while `bus_rd` is low.
- R9: A synchronous reset clears both enable words and both status words, and `cpu_irq` reads low after the reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| src_hi | input | 32 | High-bank source lines, level sensitive |
| src_lo | input | 32 | Low-bank source lines, level sensitive |
| bus_addr | input | 18 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data, little-endian byte order |
| bus_rdata | output | 32 | Read data, combinational from the offset |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
The assertions take the source lines and bus strobes as synchronous to `clk` and stable around each rising edge. They also assume that a read and a write never fall in the same cycle and that at most one clear or enable write targets a bank per edge. The bench changes every input only on the falling edge, raises one strobe at a time for exactly one cycle, and reads only while writes are idle. Reset is applied for whole cycles, so no property is judged across a partial reset.

// File: rtl/irq_merge_pkg.sv
package irq_merge_pkg;

    localparam int DATA_W  = 32;
    localparam int NBYTES  = DATA_W / 8;
    localparam int NBANK   = 2;
    localparam int BANK_LO = 0;
    localparam int BANK_HI = 1;

    // Per-bank register layout relative to the bank base
    localparam int OFS_STAT = 'h0;
    localparam int OFS_EN   = 'h4;
    localparam int OFS_CLR  = 'h8;
    localparam int OFS_RSVD = 'hC;

    localparam int OFS_VERSION = 'h00;
    localparam logic [DATA_W-1:0] VERSION_WORD = 32'h0200_0000;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

    function automatic int bank_base(input int bank);
        return (bank == BANK_HI) ? 'h10 : 'h20;
    endfunction

    // Reverse byte order of a bus word (little-endian bus to internal order)
    function automatic logic [DATA_W-1:0] lane_swap(input logic [DATA_W-1:0] w);
        logic [DATA_W-1:0] r;
        for (int b = 0; b < NBYTES; b++) begin
            r[b*8 +: 8] = w[(NBYTES-1-b)*8 +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_bank.sv
module irq_bank
    import irq_merge_pkg::*;
#(
    parameter int WIDTH = DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] src,
    input  logic             en_we,
    input  logic [WIDTH-1:0] en_data,
    input  logic             clr_en,
    input  logic [WIDTH-1:0] clr_mask,
    output logic [WIDTH-1:0] status,
    output logic [WIDTH-1:0] enable,
    output logic             pending
);

    logic [WIDTH-1:0] status_q;
    logic [WIDTH-1:0] enable_q;
    logic [WIDTH-1:0] status_d;

    always_comb begin
        if (clr_en) begin
            status_d = src & ~clr_mask;
        end else begin
            status_d = src;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            enable_q <= '0;
        end else begin
            status_q <= status_d;
            if (en_we) begin
                enable_q <= en_data;
            end
        end
    end

    assign status  = status_q;
    assign enable  = enable_q;
    assign pending = |(status_q & enable_q);

    // R2: status tracks the source lines when no clear is applied
    assert_status_follow_R2: assert property (@(posedge clk) disable iff (rst)
        !clr_en |=> status_q == $past(src));

    // R4: cleared bits are low right after a clear write
    assert_clear_applied_R4: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> (status_q & $past(clr_mask)) == '0);

    // R3: enable is replaced by the written word
    assert_enable_load_R3: assert property (@(posedge clk) disable iff (rst)
        en_we |=> enable_q == $past(en_data));

    // R3: enable holds when not written
    assert_enable_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !en_we |=> $stable(enable_q));

endmodule

// File: rtl/irq_regbus.sv
module irq_regbus
    import irq_merge_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic                         bus_wr,
    input  logic                         bus_rd,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    input  logic [NBANK-1:0][DATA_W-1:0] status,
    input  logic [NBANK-1:0][DATA_W-1:0] enable,
    output logic [NBANK-1:0]             en_we,
    output logic [NBANK-1:0]             clr_en,
    output logic [DATA_W-1:0]            wmask,
    output logic [DATA_W-1:0]            bus_rdata
);

    assign wmask = lane_swap(bus_wdata);

    always_comb begin
        en_we     = '0;
        clr_en    = '0;
        bus_rdata = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (bus_wr && bus_addr == ADDR_W'(bank_base(b) + OFS_EN)) begin
                en_we[b] = 1'b1;
            end
            if (bus_wr && bus_addr == ADDR_W'(bank_base(b) + OFS_CLR)) begin
                clr_en[b] = 1'b1;
            end
            if (bus_rd && bus_addr == ADDR_W'(bank_base(b) + OFS_STAT)) begin
                bus_rdata = status[b] & enable[b];
            end
            if (bus_rd && bus_addr == ADDR_W'(bank_base(b) + OFS_EN)) begin
                bus_rdata = enable[b];
            end
        end
        if (bus_rd && bus_addr == ADDR_W'(OFS_VERSION)) begin
            bus_rdata = VERSION_WORD;
        end
    end

    // R8: a single write strobe never targets more than one bank register
    always_comb begin
        assert_one_target_R8: assert ($onehot0({en_we, clr_en}));
    end

endmodule

// File: rtl/irq_line_fsm.sv
module irq_line_fsm
    import irq_merge_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pend_any,
    output logic irq
);

    irq_state_e state_q;
    irq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (pend_any)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!pend_any) state_d = IRQ_QUIET;
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        irq = (state_q == IRQ_RAISED);
    end

    // R1: a change of the pending condition is seen one edge later
    assert_irq_rise_R1: assert property (@(posedge clk) disable iff (rst)
        (state_q == IRQ_QUIET && pend_any) |=> irq);
    assert_irq_fall_R1: assert property (@(posedge clk) disable iff (rst)
        (state_q == IRQ_RAISED && !pend_any) |=> !irq);

endmodule

// File: rtl/irq_merge_top.sv
module irq_merge_top
    import irq_merge_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] src_hi,
    input  logic [DATA_W-1:0] src_lo,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cpu_irq
);

    logic [NBANK-1:0][DATA_W-1:0] src_v;
    logic [NBANK-1:0][DATA_W-1:0] status_v;
    logic [NBANK-1:0][DATA_W-1:0] enable_v;
    logic [NBANK-1:0]             en_we;
    logic [NBANK-1:0]             clr_en;
    logic [NBANK-1:0]             pend_v;
    logic [DATA_W-1:0]            wmask;

    assign src_v[BANK_HI] = src_hi;
    assign src_v[BANK_LO] = src_lo;

    irq_regbus #(.ADDR_W(ADDR_W)) regbus_i (
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .status    (status_v),
        .enable    (enable_v),
        .en_we     (en_we),
        .clr_en    (clr_en),
        .wmask     (wmask),
        .bus_rdata (bus_rdata)
    );

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        irq_bank #(.WIDTH(DATA_W)) bank_i (
            .clk      (clk),
            .rst      (rst),
            .src      (src_v[g]),
            .en_we    (en_we[g]),
            .en_data  (wmask),
            .clr_en   (clr_en[g]),
            .clr_mask (wmask),
            .status   (status_v[g]),
            .enable   (enable_v[g]),
            .pending  (pend_v[g])
        );
    end

    irq_line_fsm line_i (
        .clk      (clk),
        .rst      (rst),
        .pend_any (|pend_v),
        .irq      (cpu_irq)
    );

    // R1: output equals the combined enabled-pending state of the prior cycle
    assert_irq_combined_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> cpu_irq == $past(|((status_v[BANK_HI] & enable_v[BANK_HI]) |
                                    (status_v[BANK_LO] & enable_v[BANK_LO]))));

endmodule

// File: tb/irq_merge_tb.sv
module irq_merge_top_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_hi = '0;
    logic [31:0] src_lo = '0;
    logic [17:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cpu_irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_merge_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .src_hi    (src_hi),
        .src_lo    (src_lo),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cpu_irq   (cpu_irq)
    );

    function automatic logic [31:0] rev(input logic [31:0] x);
        return {x[7:0], x[15:8], x[23:16], x[31:24]};
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [17:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [17:0] a, input logic [31:0] exp, input string req);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1;
        check(bus_rdata, exp, req);
        bus_rd   = 1'b0;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        // R9 reset state
        check({31'b0, cpu_irq}, 0, "R9 irq after reset");
        rd(18'h14, 0, "R9 enable hi after reset");
        rd(18'h24, 0, "R9 enable lo after reset");
        rd(18'h10, 0, "R9 status hi after reset");
        rd(18'h20, 0, "R9 status lo after reset");
        rd(18'h00, 32'h0200_0000, "R6 version word");
        // R8 read strobe low gives zero
        bus_addr = 18'h00; #1;
        check(bus_rdata, 0, "R8 rdata idle");

        // R7 byte reversal
        wr(18'h14, 32'h1122_3344);
        rd(18'h14, 32'h4433_2211, "R7 swap hi enable");
        wr(18'h14, 0);

        // Sweep every line of both banks: R1, R2, R3, R5
        for (int b = 0; b < 2; b++) begin
            for (int i = 0; i < 32; i++) begin
                logic [31:0] one;
                logic [17:0] base;
                one  = 32'h1 << i;
                base = (b == 1) ? 18'h10 : 18'h20;
                if (b == 1) begin src_hi = one; src_lo = 32'hFFFF_FFFF; end
                else        begin src_lo = one; src_hi = 32'hFFFF_FFFF; end
                cyc(1);
                wr(base + 18'h4, rev(one));
                check({31'b0, cpu_irq}, 0, "R1 irq not yet raised");
                cyc(1);
                check({31'b0, cpu_irq}, 1, "R1 irq raised one clock later");
                rd(base, one, "R5 masked status single line");
                rd(base + 18'h4, one, "R3 enable readback");
                wr(base + 18'h4, rev(~one));
                cyc(1);
                check({31'b0, cpu_irq}, 0, "R1 irq low with line masked");
                rd(base, 0, "R5 masked status zero");
                src_hi = '0; src_lo = '0;
                wr(base + 18'h4, rev(32'hFFFF_FFFF));
                cyc(1);
                rd(base, 0, "R2 status cleared by low line");
                check({31'b0, cpu_irq}, 0, "R2 irq low with lines low");
                wr(base + 18'h4, 0);
            end
        end

        // R4 clear with held source
        src_hi = 32'h20;
        wr(18'h14, 32'hFFFF_FFFF);
        cyc(1);
        check({31'b0, cpu_irq}, 1, "R4 irq before clear");
        wr(18'h18, rev(32'h20));
        rd(18'h10, 0, "R4 status cleared on edge");
        cyc(1);
        check({31'b0, cpu_irq}, 0, "R4 irq dropped after clear");
        rd(18'h10, 32'h20, "R4 held source sets again");
        cyc(1);
        check({31'b0, cpu_irq}, 1, "R4 irq back");
        src_hi = 32'h21;
        cyc(1);
        wr(18'h18, rev(32'h20));
        rd(18'h10, 32'h01, "R4 other bits kept");
        wr(18'h28, rev(32'hFFFF_FFFF));
        rd(18'h10, 32'h21, "R4 low clear leaves high bank");

        // R6/R8 ignored writes and zero reads
        wr(18'h14, rev(32'h1234_5678));
        wr(18'h24, rev(32'h0BAD_F00D));
        src_lo = 32'h0000_F00F;
        wr(18'h00, 32'hFFFF_FFFF);
        wr(18'h1C, 32'hFFFF_FFFF);
        wr(18'h2C, 32'hFFFF_FFFF);
        wr(18'h10, 32'hFFFF_FFFF);
        wr(18'h20, 32'hFFFF_FFFF);
        wr(18'h30, 32'hFFFF_FFFF);
        wr(18'h04, 32'hFFFF_FFFF);
        rd(18'h14, 32'h1234_5678, "R8 hi enable unchanged");
        rd(18'h24, 32'h0BAD_F00D, "R8 lo enable unchanged");
        rd(18'h00, 32'h0200_0000, "R6 version after write");
        rd(18'h10, 32'h0000_0020, "R8 hi status unchanged");
        rd(18'h20, 32'h0000_F00D, "R8 lo status unchanged");
        rd(18'h1C, 0, "R8 reserved hi reads zero");
        rd(18'h2C, 0, "R8 reserved lo reads zero");
        rd(18'h18, 0, "R8 clear hi reads zero");
        rd(18'h28, 0, "R8 clear lo reads zero");
        rd(18'h30, 0, "R8 unmapped reads zero");
        rd(18'h3_FFFC, 0, "R8 far unmapped reads zero");

        // R1 both banks contribute
        wr(18'h14, 0);
        cyc(1);
        check({31'b0, cpu_irq}, 1, "R1 low bank alone keeps irq");
        wr(18'h24, 0);
        cyc(1);
        check({31'b0, cpu_irq}, 0, "R1 both masked irq low");

        // R9 reset mid-run
        wr(18'h14, 32'hFFFF_FFFF);
        wr(18'h24, 32'hFFFF_FFFF);
        cyc(1);
        check({31'b0, cpu_irq}, 1, "R9 irq before reset");
        rst = 1'b1;
        cyc(1);
        rst = 1'b0;
        check({31'b0, cpu_irq}, 0, "R9 irq low after reset edge");
        rd(18'h14, 0, "R9 hi enable cleared");
        rd(18'h24, 0, "R9 lo enable cleared");
        cyc(2);
        check({31'b0, cpu_irq}, 0, "R9 irq stays low with enables cleared");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule